// File: doc/BRIEF.md
# PCIe Configuration Address Translator

This block turns a configuration request, described by bus number, device/function number, register offset, access size and direction, into one or two 32-bit accesses on a simple memory port. The memory port either reaches the root port's own register space or a 1 MB outbound window near the top of a 16 MB aperture. The window is split into four 256 KB regions. The first three serve buses 1 to 3 directly, with no reprogramming, for device/function numbers up to 3. Every other downstream request goes through the fourth region, which the block retargets just before the access. Retargeting uses a one-cycle load pulse that carries the new target and the configuration type code.

Reads of one or two bytes return the selected lanes shifted down to bit 0. Writes of one or two bytes are done as a read of the containing word, a lane merge and a write-back. Each request ends with a single-cycle done pulse and a 2-bit completion code. A new request is accepted only when the block is idle.

Top module: `pcie_cfg_xlat`

## Requirements
- R1: After reset, done, mem_req and rgn_load are low and status reads 0.
- R2: A request on bus 0 with devfn 0 makes a local access (mem_local high) at address offset AND 0xFFC, with no region load.
- R3: A request on bus 0 with a nonzero devfn, on a bus above 15, or with devfn above 0xFF completes with status 1 (device not found), makes no memory access, and a read returns 0xFFFFFFFF.
- R4: A request on bus 1 to 3 with devfn 0 to 3 accesses window address 0x01F00000 + ((bus-1)<<18) + (devfn<<16) + (offset AND 0xFFFC) with no region load.
- R5: Any other accepted downstream request first pulses rgn_load for one cycle with rgn_target = (bus<<24)|(devfn<<16), and then accesses 0x01F00000 + 0xC0000 + (offset AND 0xFFFC).
- R6: rgn_type is 4 (type 0 configuration) when the bus is 1 and 5 (type 1) on higher buses.
- R7: Every window access stays inside the 1 MB window minus its top 16 KB: below 0x01FFC000 and at or above 0x01F00000.
- R8: A read of size 1 or 2 returns the word shifted right by 8*(offset AND 3) and masked to 8 or 16 bits; a size-4 read returns the whole word.
- R9: A size-4 write makes exactly one write of req_wdata. A size 1 or 2 write makes one read and then one write of the word, with the addressed lanes replaced by the low 8 or 16 bits of req_wdata shifted left by 8*(offset AND 3). The address and direction hold steady until mem_ack.
- R10: An address-valid request whose size is not 1, 2 or 4 completes with status 2 (bad register), makes no memory access, and a read returns 0xFFFFFFFF.
- R11: done is high for exactly one cycle per accepted request. Status 0 means success. A req_valid that arrives while a request is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 9 | Device/function number |
| req_offset | input | 16 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write value, right-aligned |
| done | output | 1 | Completion pulse |
| status | output | 2 | 0 success, 1 device not found, 2 bad register |
| rdata | output | 32 | Read result, valid with done |
| rgn_load | output | 1 | Retarget pulse for the shared region |
| rgn_target | output | 32 | Target address for the shared region |
| rgn_type | output | 5 | Configuration type code for the shared region |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | Memory write enable |
| mem_local | output | 1 | Access goes to local register space |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |

## Verification
A wrong decode shows at the ports in the access that follows: the address, the local flag, the region target or the type code is already wrong in the first mem_req or rgn_load cycle. A lane error shows in rdata or mem_wdata in the cycle of done or of the write. A stuck sequencer shows as a missing, doubled or extra mem_req or done within a few cycles of the request. Rejected requests are caught by the absence of any memory handshake and by the all-ones read value.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
   localparam int XLAT_AW = 32;
   localparam int XLAT_SW = 3;
   localparam int XLAT_TW = 5;

   localparam logic [XLAT_TW-1:0] CT_TYPE0 = 5'd4;
   localparam logic [XLAT_TW-1:0] CT_TYPE1 = 5'd5;

   typedef enum logic [1:0] {
      ST_OK     = 2'd0,
      ST_NODEV  = 2'd1,
      ST_BADREG = 2'd2
   } cfg_status_e;

   typedef enum logic [1:0] {
      RT_REJECT = 2'd0,
      RT_LOCAL  = 2'd1,
      RT_DIRECT = 2'd2,
      RT_REMAP  = 2'd3
   } cfg_route_e;

   typedef struct packed {
      cfg_route_e            route;
      cfg_status_e           status;
      logic [XLAT_AW-1:0]    addr;
      logic [XLAT_AW-1:0]    target;
      logic [XLAT_TW-1:0]    ctype;
   } xlat_t;

   function automatic logic size_legal(input logic [XLAT_SW-1:0] sz);
      return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
   endfunction
endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
   import cfgx_pkg::*;
#(
   parameter int BUS_W        = 8,
   parameter int DEVFN_W      = 9,
   parameter int OFS_W        = 16,
   parameter logic [XLAT_AW-1:0] WIN_BASE = 32'h01F0_0000,
   parameter int MAX_BUS      = 15,
   parameter int MAX_DEVFN    = 255,
   parameter int DIRECT_BUSES = 3,
   parameter int DIRECT_DEVFN = 3,
   parameter int SLOT_SHIFT   = 18,
   parameter int FUNC_SHIFT   = 16,
   parameter int TGT_SHIFT    = 24,
   parameter int REMAP_SLOT   = 3,
   parameter int LOCAL_BITS   = 12
) (
   input  logic [BUS_W-1:0]   bus,
   input  logic [DEVFN_W-1:0] devfn,
   input  logic [OFS_W-1:0]   ofs,
   input  logic [XLAT_SW-1:0] size,
   output xlat_t              xl
);
   localparam logic [XLAT_AW-1:0] LOCAL_MASK =
      ((XLAT_AW'(1) << LOCAL_BITS) - XLAT_AW'(1)) & ~XLAT_AW'(3);
   localparam logic [XLAT_AW-1:0] REMAP_BASE =
      WIN_BASE + (XLAT_AW'(REMAP_SLOT) << SLOT_SHIFT);

   logic [XLAT_AW-1:0] bus_x, devfn_x, ofs_word;
   logic               direct_hit, out_of_range;

   assign bus_x    = XLAT_AW'(bus);
   assign devfn_x  = XLAT_AW'(devfn);
   assign ofs_word = XLAT_AW'(ofs) & ~XLAT_AW'(3);
   assign out_of_range = (bus_x > XLAT_AW'(MAX_BUS)) || (devfn_x > XLAT_AW'(MAX_DEVFN));

   generate
      if (DIRECT_BUSES > 0) begin : g_direct
         assign direct_hit = (bus_x <= XLAT_AW'(DIRECT_BUSES)) &&
                             (devfn_x <= XLAT_AW'(DIRECT_DEVFN));
      end else begin : g_no_direct
         assign direct_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      xl        = '0;
      xl.route  = RT_REJECT;
      xl.status = ST_NODEV;
      if (bus_x == '0) begin
         if (devfn_x == '0) begin
            xl.route = RT_LOCAL;
            xl.addr  = XLAT_AW'(ofs) & LOCAL_MASK;
         end
      end else if (!out_of_range) begin
         if (direct_hit) begin
            xl.route = RT_DIRECT;
            xl.addr  = WIN_BASE + ((bus_x - XLAT_AW'(1)) << SLOT_SHIFT) +
                       (devfn_x << FUNC_SHIFT) + ofs_word;
         end else begin
            xl.route  = RT_REMAP;
            xl.addr   = REMAP_BASE + ofs_word;
            xl.target = (bus_x << TGT_SHIFT) | (devfn_x << FUNC_SHIFT);
            xl.ctype  = (bus_x == XLAT_AW'(1)) ? CT_TYPE0 : CT_TYPE1;
         end
      end
      // address checks win over the size check
      if (xl.route != RT_REJECT) begin
         if (size_legal(size)) begin
            xl.status = ST_OK;
         end else begin
            xl.status = ST_BADREG;
            xl.route  = RT_REJECT;
         end
      end
   end
endmodule

// File: rtl/cfgx_lanes.sv
module cfgx_lanes
   import cfgx_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int LO_W  = $clog2(LANES)
) (
   input  logic [DATA_W-1:0]  word,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [LO_W-1:0]    lo,
   input  logic [XLAT_SW-1:0] size,
   output logic [DATA_W-1:0]  rd_val,
   output logic [DATA_W-1:0]  merged
);
   localparam logic [DATA_W-1:0] BYTE_M = DATA_W'(16'h00FF);
   localparam logic [DATA_W-1:0] HALF_M = DATA_W'(16'hFFFF);

   logic [DATA_W-1:0] down, wval, wshift;

   assign down = word >> {lo, 3'b000};

   always_comb begin
      case (size)
         3'd1:    begin rd_val = down & BYTE_M; wval = wdata & BYTE_M; end
         3'd2:    begin rd_val = down & HALF_M; wval = wdata & HALF_M; end
         default: begin rd_val = word;          wval = wdata;          end
      endcase
   end

   assign wshift = wval << {lo, 3'b000};

   generate
      for (genvar b = 0; b < LANES; b++) begin : g_lane
         logic hit;
         assign hit = (size == 3'd4) ||
                      ((size == 3'd2) && (b >= int'(lo)) && (b < int'(lo) + 2)) ||
                      ((size == 3'd1) && (b == int'(lo)));
         assign merged[8*b +: 8] = hit ? wshift[8*b +: 8] : word[8*b +: 8];
      end
   endgenerate
endmodule

// File: rtl/pcie_cfg_xlat.sv
module pcie_cfg_xlat
   import cfgx_pkg::*;
#(
   parameter int BUS_W        = 8,
   parameter int DEVFN_W      = 9,
   parameter int OFS_W        = 16,
   parameter int DATA_W       = 32,
   parameter logic [XLAT_AW-1:0] WIN_BASE = 32'h01F0_0000,
   parameter int WIN_BYTES    = 1 << 20,
   parameter int REG_RESERVE  = 16 << 10,
   parameter int MAX_BUS      = 15,
   parameter int MAX_DEVFN    = 255,
   parameter int DIRECT_BUSES = 3,
   parameter int DIRECT_DEVFN = 3,
   parameter int SLOT_SHIFT   = 18,
   parameter int TGT_SHIFT    = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [BUS_W-1:0]    req_bus,
   input  logic [DEVFN_W-1:0]  req_devfn,
   input  logic [OFS_W-1:0]    req_offset,
   input  logic [XLAT_SW-1:0]  req_size,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                done,
   output logic [1:0]          status,
   output logic [DATA_W-1:0]   rdata,
   output logic                rgn_load,
   output logic [XLAT_AW-1:0]  rgn_target,
   output logic [XLAT_TW-1:0]  rgn_type,
   output logic                mem_req,
   output logic                mem_we,
   output logic                mem_local,
   output logic [XLAT_AW-1:0]  mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata,
   input  logic                mem_ack
);
   localparam int REMAP_SLOT = (WIN_BYTES >> SLOT_SHIFT) - 1;
   localparam logic [XLAT_AW-1:0] WIN_LIMIT = WIN_BASE + XLAT_AW'(WIN_BYTES - REG_RESERVE);
   localparam int LO_W = $clog2(DATA_W / 8);

   initial begin
      assert (DATA_W == 32) else $error("data path must be one 32-bit word");
      assert (REMAP_SLOT > DIRECT_BUSES - 1) else $error("direct windows overlap the shared region");
      assert ((REMAP_SLOT << SLOT_SHIFT) + (1 << OFS_W) <= WIN_BYTES - REG_RESERVE)
         else $error("shared region runs into the register area");
      assert (DEVFN_W > 8 && BUS_W >= 5) else $error("request fields too narrow");
   end

   typedef enum logic [2:0] {S_IDLE, S_REMAP, S_RD, S_WR, S_DONE} state_e;

   state_e              st;
   xlat_t               xl_in;
   cfg_route_e          route_q;
   cfg_status_e         status_q;
   logic [XLAT_AW-1:0]  addr_q, target_q;
   logic [XLAT_TW-1:0]  ctype_q;
   logic                wr_q;
   logic [XLAT_SW-1:0]  size_q;
   logic [LO_W-1:0]     lo_q;
   logic [DATA_W-1:0]   wdata_q, merged_q, rdata_q;
   logic [DATA_W-1:0]   rd_val, merged;
   logic                need_rd_in, need_rd_q;

   cfgx_decode #(
      .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .OFS_W(OFS_W), .WIN_BASE(WIN_BASE),
      .MAX_BUS(MAX_BUS), .MAX_DEVFN(MAX_DEVFN), .DIRECT_BUSES(DIRECT_BUSES),
      .DIRECT_DEVFN(DIRECT_DEVFN), .SLOT_SHIFT(SLOT_SHIFT), .FUNC_SHIFT(16),
      .TGT_SHIFT(TGT_SHIFT), .REMAP_SLOT(REMAP_SLOT), .LOCAL_BITS(12)
   ) u_decode (
      .bus(req_bus), .devfn(req_devfn), .ofs(req_offset), .size(req_size), .xl(xl_in)
   );

   cfgx_lanes #(.DATA_W(DATA_W)) u_lanes (
      .word(mem_rdata), .wdata(wdata_q), .lo(lo_q), .size(size_q),
      .rd_val(rd_val), .merged(merged)
   );

   assign need_rd_in = !req_write || (req_size != 3'd4);
   assign need_rd_q  = !wr_q || (size_q != 3'd4);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         route_q  <= RT_REJECT;
         status_q <= ST_OK;
         addr_q   <= '0;
         target_q <= '0;
         ctype_q  <= '0;
         wr_q     <= 1'b0;
         size_q   <= '0;
         lo_q     <= '0;
         wdata_q  <= '0;
         merged_q <= '0;
         rdata_q  <= '0;
      end else begin
         case (st)
            S_IDLE: if (req_valid) begin
               route_q  <= xl_in.route;
               addr_q   <= xl_in.addr;
               target_q <= xl_in.target;
               ctype_q  <= xl_in.ctype;
               wr_q     <= req_write;
               size_q   <= req_size;
               lo_q     <= req_offset[LO_W-1:0];
               wdata_q  <= req_wdata;
               case (xl_in.route)
                  RT_REJECT: begin
                     status_q <= xl_in.status;
                     rdata_q  <= '1;
                     st       <= S_DONE;
                  end
                  RT_REMAP: st <= S_REMAP;
                  default:  st <= need_rd_in ? S_RD : S_WR;
               endcase
            end
            S_REMAP: st <= need_rd_q ? S_RD : S_WR;
            S_RD: if (mem_ack) begin
               merged_q <= merged;
               if (wr_q) begin
                  st <= S_WR;
               end else begin
                  rdata_q  <= rd_val;
                  status_q <= ST_OK;
                  st       <= S_DONE;
               end
            end
            S_WR: if (mem_ack) begin
               status_q <= ST_OK;
               st       <= S_DONE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign done       = (st == S_DONE);
   assign status     = status_q;
   assign rdata      = rdata_q;
   assign rgn_load   = (st == S_REMAP);
   assign rgn_target = target_q;
   assign rgn_type   = ctype_q;
   assign mem_req    = (st == S_RD) || (st == S_WR);
   assign mem_we     = (st == S_WR);
   assign mem_local  = (route_q == RT_LOCAL);
   assign mem_addr   = addr_q;
   assign mem_wdata  = (size_q == 3'd4) ? wdata_q : merged_q;

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_remap_then_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_load |=> mem_req && !mem_local);

   assert_type_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_load |-> ((rgn_type == CT_TYPE0) || (rgn_type == CT_TYPE1)) &&
                   ((rgn_type == CT_TYPE0) == ((rgn_target >> TGT_SHIFT) == XLAT_AW'(1))));

   assert_window_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_local) |-> (mem_addr >= WIN_BASE) && (mem_addr < WIN_LIMIT));

   assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   assert_reject_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (status != 2'd0) && !wr_q) |-> (rdata == '1));
endmodule

// File: tb/pcie_cfg_xlat_test.sv
`timescale 1ns/1ps
module pcie_cfg_xlat_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_bus = '0;
   logic [8:0]  req_devfn = '0;
   logic [15:0] req_offset = '0;
   logic [2:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        done, rgn_load, mem_req, mem_we, mem_local;
   logic [1:0]  status;
   logic [31:0] rdata, rgn_target, mem_addr, mem_wdata;
   logic [4:0]  rgn_type;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   always #2 clk = ~clk;

   pcie_cfg_xlat uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
      .req_size(req_size), .req_wdata(req_wdata), .done(done), .status(status),
      .rdata(rdata), .rgn_load(rgn_load), .rgn_target(rgn_target), .rgn_type(rgn_type),
      .mem_req(mem_req), .mem_we(mem_we), .mem_local(mem_local), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   function automatic logic [31:0] mdl(input logic loc, input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ (loc ? 32'hC3C3_0F0F : 32'h1357_9BDF);
   endfunction

   // memory model: one-cycle acknowledge
   always @(posedge clk) begin
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= mdl(mem_local, mem_addr);
   end

   // port monitor
   logic        mon_clr = 1'b0;
   int          n_rd, n_wr, n_rgn, n_done, n_lim;
   logic        rgn_first;
   logic [31:0] last_addr, last_wdata, last_tgt;
   logic [4:0]  last_type;
   logic        last_local;
   always @(posedge clk) begin
      if (mon_clr) begin
         n_rd = 0; n_wr = 0; n_rgn = 0; n_done = 0; n_lim = 0; rgn_first = 1'b0;
      end else begin
         if (rgn_load) begin
            n_rgn++;
            rgn_first = (n_rd + n_wr == 0);
            last_tgt  = rgn_target;
            last_type = rgn_type;
         end
         if (mem_req && mem_ack) begin
            if (mem_we) begin n_wr++; last_wdata = mem_wdata; end
            else n_rd++;
            last_addr  = mem_addr;
            last_local = mem_local;
            if (!mem_local && (mem_addr < 32'h01F0_0000 || mem_addr >= 32'h01FF_C000)) n_lim++;
         end
         if (done) n_done++;
      end
   end

   int n_chk = 0, n_fail = 0;
   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R11 actual=%h expected=%h", cyc, 0);
         finish_run();
      end
   end

   typedef struct packed {
      logic        wr;
      logic [7:0]  bus;
      logic [8:0]  devfn;
      logic [15:0] ofs;
      logic [2:0]  size;
      logic [31:0] wdata;
      logic [1:0]  st;     // expected status
      logic [1:0]  rt;     // 0 none, 1 local, 2 direct, 3 retargeted
      logic [31:0] addr;
      logic [31:0] tgt;
      logic [4:0]  ctype;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 8'd0,  9'd0,    16'h0010, 3'd4, 32'h0,        2'd0, 2'd1, 32'h0000_0010, 32'h0,         5'd0},
      '{1'b0, 8'd0,  9'd0,    16'h1FFE, 3'd2, 32'h0,        2'd0, 2'd1, 32'h0000_0FFC, 32'h0,         5'd0},
      '{1'b0, 8'd0,  9'd1,    16'h0000, 3'd4, 32'h0,        2'd1, 2'd0, 32'h0,         32'h0,         5'd0},
      '{1'b0, 8'd16, 9'd0,    16'h0000, 3'd4, 32'h0,        2'd1, 2'd0, 32'h0,         32'h0,         5'd0},
      '{1'b0, 8'd2,  9'h100,  16'h0000, 3'd4, 32'h0,        2'd1, 2'd0, 32'h0,         32'h0,         5'd0},
      '{1'b0, 8'd1,  9'd0,    16'h0004, 3'd4, 32'h0,        2'd0, 2'd2, 32'h01F0_0004, 32'h0,         5'd0},
      '{1'b0, 8'd3,  9'd3,    16'hFFFF, 3'd1, 32'h0,        2'd0, 2'd2, 32'h01FB_FFFC, 32'h0,         5'd0},
      '{1'b0, 8'd2,  9'd1,    16'h0102, 3'd2, 32'h0,        2'd0, 2'd2, 32'h01F5_0100, 32'h0,         5'd0},
      '{1'b0, 8'd1,  9'd4,    16'h0008, 3'd4, 32'h0,        2'd0, 2'd3, 32'h01FC_0008, 32'h0104_0000, 5'd4},
      '{1'b0, 8'd4,  9'd0,    16'h003C, 3'd1, 32'h0,        2'd0, 2'd3, 32'h01FC_003C, 32'h0400_0000, 5'd5},
      '{1'b0, 8'd15, 9'hFF,   16'hFFFD, 3'd1, 32'h0,        2'd0, 2'd3, 32'h01FC_FFFC, 32'h0FFF_0000, 5'd5},
      '{1'b1, 8'd2,  9'd2,    16'h0010, 3'd4, 32'hDEADBEEF, 2'd0, 2'd2, 32'h01F6_0010, 32'h0,         5'd0},
      '{1'b1, 8'd1,  9'd0,    16'h0006, 3'd2, 32'h1234ABCD, 2'd0, 2'd2, 32'h01F0_0004, 32'h0,         5'd0},
      '{1'b1, 8'd5,  9'h21,   16'h0013, 3'd1, 32'h000000A5, 2'd0, 2'd3, 32'h01FC_0010, 32'h0521_0000, 5'd5},
      '{1'b1, 8'd0,  9'd0,    16'h0101, 3'd1, 32'h00000077, 2'd0, 2'd1, 32'h0000_0100, 32'h0,         5'd0},
      '{1'b0, 8'd1,  9'd0,    16'h0000, 3'd3, 32'h0,        2'd2, 2'd0, 32'h0,         32'h0,         5'd0},
      '{1'b1, 8'd2,  9'd0,    16'h0000, 3'd0, 32'h1,        2'd2, 2'd0, 32'h0,         32'h0,         5'd0},
      '{1'b0, 8'd0,  9'd0,    16'h0000, 3'd5, 32'h0,        2'd2, 2'd0, 32'h0,         32'h0,         5'd0},
      '{1'b1, 8'd20, 9'd0,    16'h0000, 3'd4, 32'h5,        2'd1, 2'd0, 32'h0,         32'h0,         5'd0},
      '{1'b0, 8'd2,  9'h08,   16'h0040, 3'd4, 32'h0,        2'd0, 2'd3, 32'h01FC_0040, 32'h0208_0000, 5'd5}
   };

   function automatic logic [31:0] exp_read(input logic [31:0] w, input logic [15:0] ofs, input logic [2:0] sz);
      int sh = 8 * int'(ofs[1:0]);
      if (sz == 3'd1) return (w >> sh) & 32'hFF;
      if (sz == 3'd2) return (w >> sh) & 32'hFFFF;
      return w;
   endfunction

   function automatic logic [31:0] exp_merge(input logic [31:0] w, input logic [31:0] d,
                                             input logic [15:0] ofs, input logic [2:0] sz);
      int sh = 8 * int'(ofs[1:0]);
      logic [31:0] m = (sz == 3'd2) ? 32'hFFFF : 32'hFF;
      return (w & ~(m << sh)) | ((d & m) << sh);
   endfunction

   task automatic issue(input logic wr, input logic [7:0] bus, input logic [8:0] devfn,
                        input logic [15:0] ofs, input logic [2:0] sz, input logic [31:0] wd);
      @(negedge clk); mon_clr = 1'b1;
      @(negedge clk); mon_clr = 1'b0;
      req_valid = 1'b1; req_write = wr; req_bus = bus; req_devfn = devfn;
      req_offset = ofs; req_size = sz; req_wdata = wd;
      @(negedge clk); req_valid = 1'b0;
   endtask

   task automatic wait_done();
      int t = 0;
      while (!done && t < 200) begin @(negedge clk); t++; end
      chk(done, "R11 done seen", {31'b0, done}, 32'h1);
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      logic [31:0] w;
      issue(v.wr, v.bus, v.devfn, v.ofs, v.size, v.wdata);
      wait_done();
      chk(status == v.st, $sformatf("R11 status vec %0d", idx), {30'b0, status}, {30'b0, v.st});
      if (v.st != 2'd0) begin
         chk(n_rd + n_wr == 0, $sformatf("R3 R10 no access vec %0d", idx), n_rd + n_wr, 0);
         chk(n_rgn == 0, $sformatf("R3 R10 no load vec %0d", idx), n_rgn, 0);
         if (!v.wr) chk(rdata == 32'hFFFF_FFFF, $sformatf("R3 R10 ones vec %0d", idx), rdata, 32'hFFFF_FFFF);
      end else begin
         w = mdl(v.rt == 2'd1, v.addr);
         chk(last_addr == v.addr, $sformatf("R2 R4 R5 address vec %0d", idx), last_addr, v.addr);
         chk(last_local == (v.rt == 2'd1), $sformatf("R2 local flag vec %0d", idx), {31'b0, last_local}, {31'b0, v.rt == 2'd1});
         chk(n_rgn == ((v.rt == 2'd3) ? 1 : 0), $sformatf("R5 load count vec %0d", idx), n_rgn, (v.rt == 2'd3) ? 1 : 0);
         chk(n_lim == 0, $sformatf("R7 window limit vec %0d", idx), n_lim, 0);
         if (v.rt == 2'd3) begin
            chk(rgn_first, $sformatf("R5 load before access vec %0d", idx), {31'b0, rgn_first}, 32'h1);
            chk(last_tgt == v.tgt, $sformatf("R5 target vec %0d", idx), last_tgt, v.tgt);
            chk(last_type == v.ctype, $sformatf("R6 type vec %0d", idx), {27'b0, last_type}, {27'b0, v.ctype});
         end
         if (!v.wr) begin
            chk(n_rd == 1 && n_wr == 0, $sformatf("R8 one read vec %0d", idx), n_rd * 16 + n_wr, 16);
            chk(rdata == exp_read(w, v.ofs, v.size), $sformatf("R8 read data vec %0d", idx), rdata, exp_read(w, v.ofs, v.size));
         end else if (v.size == 3'd4) begin
            chk(n_rd == 0 && n_wr == 1, $sformatf("R9 single write vec %0d", idx), n_rd * 16 + n_wr, 1);
            chk(last_wdata == v.wdata, $sformatf("R9 write data vec %0d", idx), last_wdata, v.wdata);
         end else begin
            chk(n_rd == 1 && n_wr == 1, $sformatf("R9 read-modify-write vec %0d", idx), n_rd * 16 + n_wr, 17);
            chk(last_wdata == exp_merge(w, v.wdata, v.ofs, v.size), $sformatf("R9 merged data vec %0d", idx),
                last_wdata, exp_merge(w, v.wdata, v.ofs, v.size));
         end
      end
      @(negedge clk);
      chk(!done && n_done == 1, $sformatf("R11 single done vec %0d", idx), n_done, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!done && !mem_req && !rgn_load && status == 2'd0, "R1 reset outputs",
          {done, mem_req, rgn_load, 27'b0, status}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !mem_req && !rgn_load, "R1 idle after reset", {29'b0, done, mem_req, rgn_load}, 32'h0);

      for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

      // R11: a request while busy is ignored
      @(negedge clk); mon_clr = 1'b1;
      @(negedge clk); mon_clr = 1'b0;
      req_valid = 1'b1; req_write = 1'b0; req_bus = 8'd6; req_devfn = 9'd0;
      req_offset = 16'h0020; req_size = 3'd4;
      @(negedge clk);
      req_bus = 8'd7; req_devfn = 9'd9; req_offset = 16'h0080;
      @(negedge clk); req_valid = 1'b0;
      wait_done();
      chk(rdata == mdl(1'b0, 32'h01FC_0020), "R11 busy first result", rdata, mdl(1'b0, 32'h01FC_0020));
      chk(last_tgt == 32'h0600_0000, "R11 busy target kept", last_tgt, 32'h0600_0000);
      repeat (8) @(negedge clk);
      chk(n_done == 1 && n_rgn == 1 && n_rd == 1, "R11 busy request dropped", n_done * 256 + n_rgn * 16 + n_rd, 32'h111);

      finish_run();
   end
endmodule